// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external 8K x 8 asynchronous static RAM. The host presents a request with a valid/ready handshake: address, write data and a write flag. Every accepted request is answered by a one-cycle response pulse, which carries the read data for a read. The response has no back-pressure, so the host must take it in the cycle it is offered. A request waits, with its fields held steady, for as long as `req_ready` is low.

On the memory side the controller drives the address lines and a complementary pair of chip selects, one active low and one active high. It also drives an active-low read (output) strobe and an active-low write strobe. The data bus is split into an outgoing word, an incoming word and a drive enable, so an outer pad ring can build the bidirectional bus.

The memory is deselected whenever no access is in progress, which keeps it in its power-down state. The controller drives the bus only during write cycles. Access length is set by the memory's access time and the clock period: the parameters `ACCESS_NS` and `CLK_NS` give the number of wait cycles, rounded up, with a minimum of one. All memory pins are driven from registers.

Top module: `sram_host_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_sel_n`=1, `mem_sel`=0, `mem_rd_n`=1, `mem_wr_n`=1, `mem_drive`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: Whenever `req_ready` is high, the memory is deselected (`mem_sel_n`=1 and `mem_sel`=0). The two selects are always of opposite value.
- R3: A write asserts both selects and drives `mem_dout` for one setup cycle with `mem_wr_n` high. It then holds `mem_wr_n` low, then keeps one hold cycle with `mem_wr_n` high and selects and drive still on. Address and write data do not change from the setup cycle to the hold cycle.
- R4: `mem_drive` is high only in write setup, pulse and hold cycles. Whenever `mem_drive` is high, `mem_rd_n` is high. Whenever `mem_rd_n` is low, `mem_wr_n` is high and `mem_drive` is low.
- R5: A read holds both selects active and `mem_rd_n` low for WAIT cycles. It samples `mem_din` at the clock edge that ends the last of them and shows that word on `rsp_rdata` in the response cycle. `rsp_rdata` then holds its value until the next read completes; writes leave it unchanged.
- R6: Each accepted request gives exactly one one-cycle `rsp_valid` pulse. Count the cycle of the accepting edge as 0. The pulse comes in cycle WAIT+1 for a read and in cycle WAIT+3 for a write.
- R7: `req_ready` is high only when the controller is idle or in a response cycle. A request is taken at a clock edge where `req_valid` and `req_ready` are both high. While an access is in progress `req_ready` is low.
- R8: A request accepted in a response cycle starts in the next cycle, with no extra deselect cycle. The only exception is the case in R9.
- R9: A write accepted in the response cycle of a read gets one turnaround cycle before its setup cycle. In that cycle the memory is deselected, `mem_rd_n` is high and `mem_drive` is low, so its response comes in cycle WAIT+4. A write accepted from idle after a read has no turnaround.
- R10: WAIT is ceil(`ACCESS_NS`/`CLK_NS`), with a minimum of 1. `mem_wr_n` stays low for exactly WAIT consecutive cycles in each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last word read |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_dout | output | DATA_W | Data toward memory |
| mem_din | input | DATA_W | Data from memory |
| mem_drive | output | 1 | Controller drives the data bus |

## Verification
A read response and the acceptance of the next request fall in the same cycle. This is the only point where the bus changes owner, from the memory to the controller. The bench provokes it by issuing each new request in the very cycle it sees `rsp_valid`, alternating write and read on every address. It judges the result by the response latency, which must grow by exactly one cycle for a write after a read and by no cycle otherwise. A bus monitor must also never see the controller drive while the memory model drives, and the data read back must be the data just written.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_TURN,
    ST_DONE
  } bridge_state_t;

  // Cycles needed to cover an access time, rounded up, at least one.
  function automatic int wait_cycles(input int acc_ns, input int clk_ns);
    int r;
    r = (acc_ns + clk_ns - 1) / clk_ns;
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/sram_bridge_seq.sv
module sram_bridge_seq
  import sram_bridge_pkg::*;
#(
  parameter int WAIT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  output bridge_state_t state_q,
  output bridge_state_t state_d,
  output logic          req_ready,
  output logic          accept,
  output logic          capture,
  output logic          rsp_valid
);

  logic last;
  logic last_rd;

  assign req_ready = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign accept    = req_ready && req_valid;
  assign rsp_valid = (state_q == ST_DONE);
  assign capture   = (state_q == ST_RD) && last;

  generate
    if (WAIT_CYC == 1) begin : g_nocnt
      assign last = 1'b1;
    end else begin : g_cnt
      localparam int CNT_W = $clog2(WAIT_CYC);
      logic [CNT_W-1:0] cnt;
      logic             load;
      assign load = ((state_d == ST_RD) && (state_q != ST_RD)) ||
                    ((state_d == ST_WPULSE) && (state_q != ST_WPULSE));
      always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= CNT_W'(WAIT_CYC - 1);
        else if (cnt != '0) cnt <= cnt - 1'b1;
      end
      assign last = (cnt == '0);
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (req_valid) begin
          if (!req_write)                        state_d = ST_RD;
          else if (state_q == ST_DONE && last_rd) state_d = ST_TURN;
          else                                   state_d = ST_WSETUP;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_RD:     state_d = last ? ST_DONE : ST_RD;
      ST_TURN:   state_d = ST_WSETUP;
      ST_WSETUP: state_d = ST_WPULSE;
      ST_WPULSE: state_d = last ? ST_WHOLD : ST_WPULSE;
      ST_WHOLD:  state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      last_rd <= 1'b0;
    end else begin
      state_q <= state_d;
      if (capture)     last_rd <= 1'b1;
      else if (accept) last_rd <= 1'b0;
    end
  end

endmodule

// File: rtl/sram_bridge_pins.sv
module sram_bridge_pins
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bridge_state_t     state_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              mem_drive
);

  logic sel_d, drive_d, rd_d, wr_d;

  always_comb begin
    sel_d   = (state_d == ST_RD) || (state_d == ST_WSETUP) ||
              (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
    drive_d = (state_d == ST_WSETUP) || (state_d == ST_WPULSE) ||
              (state_d == ST_WHOLD);
    rd_d    = (state_d == ST_RD);
    wr_d    = (state_d == ST_WPULSE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_rd_n  <= 1'b1;
      mem_wr_n  <= 1'b1;
      mem_drive <= 1'b0;
      mem_addr  <= '0;
      mem_dout  <= '0;
    end else begin
      mem_sel_n <= ~sel_d;
      mem_sel   <= sel_d;
      mem_rd_n  <= ~rd_d;
      mem_wr_n  <= ~wr_d;
      mem_drive <= drive_d;
      if (accept) begin
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/sram_bridge_rdcap.sv
module sram_bridge_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_din,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst)          rsp_rdata <= '0;
    else if (capture) rsp_rdata <= mem_din;
  end

endmodule

// File: rtl/sram_host_bridge.sv
module sram_host_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int ACCESS_NS = 15,
  parameter int CLK_NS    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_drive
);

  localparam int WAIT_CYC = wait_cycles(ACCESS_NS, CLK_NS);

  bridge_state_t state_q, state_d;
  logic          accept, capture;

  sram_bridge_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .state_q   (state_q),
    .state_d   (state_d),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .rsp_valid (rsp_valid)
  );

  sram_bridge_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_addr  (mem_addr),
    .mem_dout  (mem_dout),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_drive (mem_drive)
  );

  sram_bridge_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .mem_din   (mem_din),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_host_bridge_chk.sv
module sram_host_bridge_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dout,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_rd_n,
  input logic              mem_wr_n,
  input logic              mem_drive
);

  assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_sel_n && !mem_sel));

  assert_sel_pair_R2: assert property (@(posedge clk) disable iff (rst)
    mem_sel_n != mem_sel);

  assert_wr_after_setup_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr_n) |-> ($past(!mem_sel_n) && $past(mem_drive)));

  assert_wr_hold_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n) |-> (!mem_sel_n && mem_drive));

  assert_wr_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!mem_wr_n && $past(!mem_wr_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

  assert_drive_no_rd_R4: assert property (@(posedge clk) disable iff (rst)
    mem_drive |-> mem_rd_n);

  assert_rd_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |-> (mem_wr_n && !mem_drive));

  assert_rdata_moves_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_rdata) |-> rsp_valid);

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_rsp_ready_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

endmodule

bind sram_host_bridge sram_host_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .mem_addr  (mem_addr),
  .mem_dout  (mem_dout),
  .mem_sel_n (mem_sel_n),
  .mem_sel   (mem_sel),
  .mem_rd_n  (mem_rd_n),
  .mem_wr_n  (mem_wr_n),
  .mem_drive (mem_drive)
);

// File: tb/sram_async_model.sv
module sram_async_model #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 3
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] q,
  output logic              q_en
);

  logic [DATA_W-1:0] arr [2**ADDR_W];
  int                age;
  logic              chosen;

  assign chosen = !sel_n && sel;
  assign q_en   = chosen && !rd_n && wr_n;
  // Data is only valid once the read has lasted the full access time.
  assign q      = (age >= ACC_CYC - 1) ? arr[addr] : 8'h5A;

  initial age = 0;

  always @(posedge clk) begin
    if (q_en) age <= age + 1;
    else      age <= 0;
  end

  always @(negedge clk) begin
    if (chosen && !wr_n) arr[addr] <= bus_in;
  end

endmodule

// File: tb/test_sram_host_bridge.sv
`timescale 1ns/1ps
module test_sram_host_bridge;

  localparam int AW   = 10;
  localparam int DW   = 8;
  localparam int ACC  = 20;
  localparam int TCK  = 8;
  localparam int WAIT = (ACC + TCK - 1) / TCK;
  localparam int NW   = 2**AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_drive;
  logic [DW-1:0] mem_dout, mem_din, m_q;
  logic          m_en;

  int errors = 0;
  int checks = 0;
  int contention = 0;
  int idle_bad = 0;
  int pulse_bad = 0;
  int pulses = 0;
  int wr_run = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign mem_din = m_en ? m_q : (mem_drive ? mem_dout : 8'hC3);

  sram_host_bridge #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_NS(ACC), .CLK_NS(TCK)) i_sram_host_bridge (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .mem_dout(mem_dout), .mem_din(mem_din),
    .mem_drive(mem_drive)
  );

  sram_async_model #(.ADDR_W(AW), .DATA_W(DW), .ACC_CYC(WAIT)) i_model (
    .clk(clk), .addr(mem_addr), .sel_n(mem_sel_n), .sel(mem_sel),
    .rd_n(mem_rd_n), .wr_n(mem_wr_n), .bus_in(mem_din), .q(m_q), .q_en(m_en)
  );

  // Pin monitors, sampled mid-cycle.
  always @(negedge clk) begin
    if (!rst) begin
      if (m_en && mem_drive) contention++;
      if (req_ready && (!mem_sel_n || mem_sel)) idle_bad++;
      if (!mem_wr_n) wr_run++;
      else if (wr_run != 0) begin
        pulses++;
        if (wr_run != WAIT) pulse_bad++;
        wr_run = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int pass);
    return DW'((a * 37 + pass * 101 + (a >> 3)) ^ (a << 1));
  endfunction

  // Issues one request starting at the current negedge, returns in the response cycle.
  task automatic xfer(input bit w, input int a, input logic [DW-1:0] d, output int lat);
    bit busy_ok;
    req_valid = 1'b1;
    req_write = w;
    req_addr  = AW'(a);
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_ok = 1;
    while (!rsp_valid && lat < 64) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      lat++;
    end
    chk(busy_ok, "R7 ready low while busy", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [DW-1:0] last_rd;
    repeat (5) @(negedge clk);
    // R1: reset state.
    chk(mem_sel_n && !mem_sel && mem_rd_n && mem_wr_n && !mem_drive && !rsp_valid && req_ready,
        "R1 reset pins", {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_drive, rsp_valid, req_ready}, 7'b1011001);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_sel_n && !mem_sel && mem_rd_n && mem_wr_n && !mem_drive && !rsp_valid && req_ready,
        "R1 after reset", {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_drive, rsp_valid, req_ready}, 7'b1011001);

    // Sweep 1: back-to-back writes of every address (R3, R6, R8).
    for (int a = 0; a < NW; a++) begin
      xfer(1'b1, a, pat(a, 0), lat);
      chk(lat == WAIT + 3, "R6 R8 write latency", lat, WAIT + 3);
    end

    // Sweep 2: back-to-back reads of every address (R5, R6, R8).
    for (int a = 0; a < NW; a++) begin
      xfer(1'b0, a, '0, lat);
      chk(lat == WAIT + 1, "R6 R8 read latency", lat, WAIT + 1);
      chk(rsp_rdata == pat(a, 0), "R5 read data", rsp_rdata, pat(a, 0));
    end

    // Sweep 3: write after read in the response cycle, then read back (R9).
    for (int a = 0; a < 256; a++) begin
      xfer(1'b1, a, pat(a, 1), lat);
      chk(lat == WAIT + 4, "R9 turnaround latency", lat, WAIT + 4);
      xfer(1'b0, a, '0, lat);
      chk(rsp_rdata == pat(a, 1), "R9 readback", rsp_rdata, pat(a, 1));
    end

    // R5 hold: a write leaves rsp_rdata alone; R9: no turnaround from idle.
    last_rd = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R7 idle ready", {rsp_valid, req_ready}, 2'b01);
    xfer(1'b1, 5, 8'h3C, lat);
    chk(lat == WAIT + 3, "R9 no turnaround from idle", lat, WAIT + 3);
    chk(rsp_rdata == last_rd, "R5 rdata unchanged by write", rsp_rdata, last_rd);
    xfer(1'b0, 5, '0, lat);
    chk(rsp_rdata == 8'h3C, "R5 R8 read after write", rsp_rdata, 8'h3C);
    @(negedge clk);
    chk(!rsp_valid, "R6 single pulse", rsp_valid, 0);

    repeat (3) @(negedge clk);
    chk(contention == 0, "R4 bus contention cycles", contention, 0);
    chk(idle_bad == 0, "R2 selected while ready", idle_bad, 0);
    chk(pulse_bad == 0, "R10 R3 write pulse length", pulse_bad, 0);
    chk(pulses == NW + 257, "R10 write pulse count", pulses, NW + 257);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule